// File: doc/BRIEF.md
# Boot Script Command Interpreter

This block executes a small boot script while the processor is still held in reset. It takes bytes from a boot ROM reader and groups them into 32-bit words, most significant byte first. It decodes the words as commands and issues the resulting register writes on a simple write-request master port. The script has four commands:

- a single register write;
- a list write, which stores a run of inline words at consecutive word addresses;
- a timed idle of a programmed number of clock cycles;
- a terminate command, which raises `done`.

The byte stream has a valid/ready handshake and a last-byte marker. The script must end on the final byte of a terminate header. If the stream ends anywhere else, the block raises `error` and stops.

Each command begins with a header word. Bits [31:30] of the header hold the opcode and bits [29:0] hold the argument.

The states of the controller are:

- `ST_HDR`: collect a header word.
- `ST_ADDR`: collect the target address.
- `ST_DATA`: collect one data word.
- `ST_WRITE`: hold a write request until it is accepted.
- `ST_WAIT`: idle for the delay.
- `ST_DONE`: the script finished.
- `ST_FAULT`: the stream ended early.

The transitions are:

- `ST_HDR` to `ST_ADDR` on a write or list header.
- `ST_HDR` to `ST_WAIT` on a delay header with a non-zero count.
- `ST_HDR` back to `ST_HDR` on a zero delay.
- `ST_HDR` to `ST_DONE` on terminate.
- `ST_ADDR` to `ST_DATA` when at least one word remains.
- `ST_ADDR` to `ST_HDR` for an empty list.
- `ST_DATA` to `ST_WRITE` on each data word.
- `ST_WRITE` back to `ST_DATA` while list words remain.
- `ST_WRITE` to `ST_HDR` after the last word.
- `ST_WAIT` to `ST_HDR` when the count runs out.
- `ST_HDR`, `ST_ADDR` or `ST_DATA` to `ST_FAULT` on a misplaced last byte.

Top module: `bootscript_exec`

## Requirements
- R1: After reset `done`, `error` and `wr_valid` are low and `in_ready` is high.
- R2: Stream bytes are packed into 32-bit words with the first byte in bits [31:24] and the fourth byte in bits [7:0].
- R3: A header opcode in bits [31:30] selects the command: 00 single write, 01 list write, 10 delay, 11 terminate. Bits [29:0] carry the word count or the cycle count. They are unused for the single write and for terminate.
- R4: A single write is a header, an address word and a data word. It produces exactly one request with that address and data.
- R5: A list write is a header carrying n, a start address and n data words. It produces n requests in stream order at the start address plus 4·k. A count of zero produces no request.
- R6: A delay header with count t holds `in_ready` low for exactly t cycles after its final byte is accepted. A count of zero causes no stall.
- R7: After the final byte of a terminate header, `done` rises and stays high and `error` stays low. `in_ready` stays high, and further bytes are discarded without any request.
- R8: A pending request keeps `wr_addr` and `wr_data` stable until `wr_ready` is seen high. No byte is accepted while it is pending.
- R9: A byte marked `in_last` that is not the final byte of a terminate header raises `error` for good. The word holding that byte is not executed, `in_ready` drops, no further request is issued and `done` stays low.
- R10: A list of 0x273 words is written completely, including its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Byte accepted at the clock edge when high with `in_valid` |
| wr_addr | output | 32 | Write request address |
| wr_data | output | 32 | Write request data |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write request accepted when high with `wr_valid` |
| done | output | 1 | Script terminated normally |
| error | output | 1 | Stream ended inside a command |

## Verification
Each result has a fixed due time:

- A write request is presented in the cycle after the final byte of its data word is accepted.
- `done` and `error` rise in the cycle after the byte that caused them.
- A delay stall starts in the cycle right after the header's final byte.

The bench drives and samples on falling edges, when all registered state and the combinational ready have settled. It counts stalled cycles from the first falling edge after the accepting rising edge, so a delay of t must show exactly t low samples. Requests are recorded at the falling edge where the bench has just set `wr_ready` high with `wr_valid` high, which is the handshake taken at the next rising edge.

// File: rtl/bscr_pkg.sv
package bscr_pkg;
    localparam int unsigned OP_W = 2;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_ADDR,
        ST_DATA,
        ST_WRITE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } bscr_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_WRITE = 2'b00,
        OP_LIST  = 2'b01,
        OP_DELAY = 2'b10,
        OP_END   = 2'b11
    } bscr_op_e;
endpackage

// File: rtl/bscr_word_pack.sv
// Packs bytes into a word, first byte most significant; the finished word is
// presented combinationally in the cycle its last byte is taken.
module bscr_word_pack #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_fire,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_fire,
    output logic [WORD_W-1:0] word_out
);
    localparam int unsigned NB    = WORD_W / BYTE_W;
    localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int unsigned HELD  = WORD_W - BYTE_W;

    logic [IDX_W-1:0] idx_q;
    logic [HELD-1:0]  held_q;

    assign word_out  = {held_q, byte_in};
    assign word_fire = byte_fire && (idx_q == IDX_W'(NB - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            held_q <= '0;
        end else if (byte_fire) begin
            idx_q  <= word_fire ? '0 : idx_q + IDX_W'(1);
            held_q <= word_out[HELD-1:0];
        end
    end
endmodule

// File: rtl/bscr_wait_timer.sv
// Down-counter for the idle command; last_cycle marks the final idle cycle.
module bscr_wait_timer #(
    parameter int unsigned CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last_cycle
);
    logic [CNT_W-1:0] cnt_q;

    assign last_cycle = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/bootscript_exec.sv
module bootscript_exec
    import bscr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              done,
    output logic              error
);
    localparam int unsigned CNT_W     = WORD_W - OP_W;
    localparam int unsigned ADDR_STEP = WORD_W / 8;

    bscr_state_e       state_q, state_d;
    logic              accepting;
    logic              byte_fire;
    logic              word_fire;
    logic [WORD_W-1:0] word;
    bscr_op_e          op;
    logic [CNT_W-1:0]  arg;
    logic              stray_end;
    logic              tmr_load;
    logic              tmr_last;
    logic [CNT_W-1:0]  remain_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    assign accepting = (state_q == ST_HDR) || (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign byte_fire = in_valid && accepting;
    assign op        = bscr_op_e'(word[WORD_W-1 -: OP_W]);
    assign arg       = word[CNT_W-1:0];
    // A last byte is only legal as the closing byte of a terminate header.
    assign stray_end = byte_fire && in_last &&
                       !((state_q == ST_HDR) && word_fire && (op == OP_END));
    assign tmr_load  = (state_q == ST_HDR) && word_fire && (op == OP_DELAY);

    bscr_word_pack #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (byte_fire),
        .byte_in   (in_data),
        .word_fire (word_fire),
        .word_out  (word)
    );

    bscr_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_val   (arg),
        .last_cycle (tmr_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HDR;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR: begin
                if (stray_end) state_d = ST_FAULT;
                else if (word_fire) begin
                    unique case (op)
                        OP_WRITE, OP_LIST: state_d = ST_ADDR;
                        OP_DELAY:          state_d = (arg == '0) ? ST_HDR : ST_WAIT;
                        OP_END:            state_d = ST_DONE;
                    endcase
                end
            end
            ST_ADDR: begin
                if (stray_end) state_d = ST_FAULT;
                else if (word_fire) state_d = (remain_q == '0) ? ST_HDR : ST_DATA;
            end
            ST_DATA: begin
                if (stray_end) state_d = ST_FAULT;
                else if (word_fire) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ready) state_d = (remain_q == CNT_W'(1)) ? ST_HDR : ST_DATA;
            end
            ST_WAIT:  if (tmr_last) state_d = ST_HDR;
            ST_DONE:  state_d = ST_DONE;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // Command datapath: word count, running address, held data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            if ((state_q == ST_HDR) && word_fire)
                remain_q <= (op == OP_WRITE) ? CNT_W'(1) : arg;
            if ((state_q == ST_ADDR) && word_fire)
                addr_q <= word;
            if ((state_q == ST_DATA) && word_fire)
                data_q <= word;
            if ((state_q == ST_WRITE) && wr_ready) begin
                addr_q   <= addr_q + WORD_W'(ADDR_STEP);
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready = accepting || (state_q == ST_DONE);
        wr_valid = (state_q == ST_WRITE);
        wr_addr  = addr_q;
        wr_data  = data_q;
        done     = (state_q == ST_DONE);
        error    = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/bscr_checker.sv
module bscr_checker #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [WORD_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              done,
    input logic              error
);
    assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_no_byte_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready && !wr_valid && !error);

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !in_ready && !wr_valid && !done);
endmodule

bind bootscript_exec bscr_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .error    (error)
);

// File: tb/bootscript_exec_test.sv
`timescale 1ns/1ps
module bootscript_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [31:0] wr_addr, wr_data;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic        done, error;

    always #4 clk = ~clk;

    bootscript_exec uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]  bq[$];
    int          dq[$];
    logic [31:0] ea[$], ed[$], ga[$], gd[$];
    bit          pend = 0;
    logic [31:0] pa, pd;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sink: pick wr_ready, then record the handshake taken at the next rising edge (R8)
    always @(negedge clk) begin
        wr_ready = ($urandom % 3) != 0;
        if (rst_n && wr_valid) begin
            chk("R8", "in_ready while pending", {63'd0, in_ready}, 64'd0);
            if (pend) begin
                chk("R8", "held addr", {32'd0, wr_addr}, {32'd0, pa});
                chk("R8", "held data", {32'd0, wr_data}, {32'd0, pd});
            end
            if (wr_ready) begin
                ga.push_back(wr_addr);
                gd.push_back(wr_data);
                pend = 0;
            end else begin
                pend = 1; pa = wr_addr; pd = wr_data;
            end
        end else pend = 0;
    end

    task automatic push_word(logic [31:0] w, int dly);
        for (int k = 0; k < 4; k++) begin
            bq.push_back(w[31-8*k -: 8]);
            dq.push_back((k == 3) ? dly : -1);
        end
    endtask

    task automatic add_write(logic [31:0] a, logic [31:0] d);
        push_word({2'b00, 30'($urandom)}, -1);
        push_word(a, -1);
        push_word(d, -1);
        ea.push_back(a); ed.push_back(d);
    endtask

    task automatic add_list(logic [31:0] a, int n, logic [31:0] seed);
        push_word({2'b01, 30'(n)}, -1);
        push_word(a, -1);
        for (int k = 0; k < n; k++) begin
            logic [31:0] d = seed ^ (32'(k) * 32'h01010101);
            push_word(d, -1);
            ea.push_back(a + 32'(4 * k)); ed.push_back(d);
        end
    endtask

    task automatic add_delay(int t);
        push_word({2'b10, 30'(t)}, t);
    endtask

    task automatic add_end();
        push_word({2'b11, 30'($urandom)}, -1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0; in_last = 1'b0;
        bq.delete(); dq.delete(); ea.delete(); ed.delete(); ga.delete(); gd.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send_byte(logic [7:0] b, logic l);
        in_valid = 1'b1; in_data = b; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_bytes(bit mark_last);
        for (int i = 0; i < bq.size(); i++) begin
            if ($urandom % 4 == 0) @(negedge clk);
            send_byte(bq[i], mark_last && (i == bq.size() - 1));
            if (dq[i] >= 0) begin
                int n = 0;
                while (!in_ready && n < 100000) begin n++; @(negedge clk); end
                chk("R6", "delay stall cycles", 64'(n), 64'(dq[i]));
            end
        end
    endtask

    task automatic settle();
        for (int k = 0; k < 400 && !(done || error); k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(string req);
        chk(req, "request count", 64'(ga.size()), 64'(ea.size()));
        for (int k = 0; k < ea.size() && k < ga.size(); k++) begin
            chk(req, "addr", {32'd0, ga[k]}, {32'd0, ea[k]});
            chk(req, "data", {32'd0, gd[k]}, {32'd0, ed[k]});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk("R1", "done", {63'd0, done}, 64'd0);
        chk("R1", "error", {63'd0, error}, 64'd0);
        chk("R1", "wr_valid", {63'd0, wr_valid}, 64'd0);
        chk("R1", "in_ready", {63'd0, in_ready}, 64'd1);

        // R2/R3/R4 directed single write, MSB-first packing; R6 zero and short delays
        add_write(32'h1BE4_7008, 32'h1122_3344);
        add_delay(0);
        add_delay(1);
        add_delay(5);
        add_list(32'h4000_0000, 0, 32'h0);          // R5 empty list
        add_end();
        run_bytes(1);
        settle();
        compare("R4");
        chk("R7", "done after terminate", {63'd0, done}, 64'd1);
        chk("R7", "error after terminate", {63'd0, error}, 64'd0);
        // R7 bytes after terminate are discarded
        bq.delete(); dq.delete();
        push_word({2'b00, 30'd0}, -1); push_word(32'h5, -1); push_word(32'h6, -1);
        run_bytes(1);
        repeat (6) @(negedge clk);
        chk("R7", "requests after done", 64'(ga.size()), 64'(ea.size()));
        chk("R7", "done held", {63'd0, done}, 64'd1);
        chk("R7", "in_ready after done", {63'd0, in_ready}, 64'd1);

        // R10 long list with a 5600-cycle delay (R6)
        do_reset();
        add_delay(32'h15E0);
        add_list(32'h4000_0000, 32'h273, 32'hC281_C181);
        add_end();
        run_bytes(1);
        settle();
        compare("R10");
        chk("R10", "done", {63'd0, done}, 64'd1);

        // R5 random mixed scripts
        for (int s = 0; s < 6; s++) begin
            int ncmd;
            do_reset();
            ncmd = 4 + ($urandom % 5);
            for (int c = 0; c < ncmd; c++) begin
                case ($urandom % 3)
                    0: add_write($urandom, $urandom);
                    1: add_list($urandom, $urandom % 7, $urandom);
                    default: add_delay($urandom % 10);
                endcase
            end
            add_end();
            run_bytes(1);
            settle();
            compare("R5");
            chk("R5", "done", {63'd0, done}, 64'd1);
        end

        // R9 stream ends inside a data word
        do_reset();
        push_word({2'b00, 30'd0}, -1); push_word(32'hA0, -1);
        bq.push_back(8'h12); dq.push_back(-1);
        bq.push_back(8'h34); dq.push_back(-1);
        run_bytes(1);
        repeat (6) @(negedge clk);
        chk("R9", "error mid word", {63'd0, error}, 64'd1);
        chk("R9", "done mid word", {63'd0, done}, 64'd0);
        chk("R9", "in_ready mid word", {63'd0, in_ready}, 64'd0);
        chk("R9", "requests mid word", 64'(ga.size()), 64'd0);

        // R9 stream ends on the last byte of a complete write: not executed
        do_reset();
        push_word({2'b00, 30'd0}, -1); push_word(32'hA4, -1); push_word(32'hBEEF, -1);
        run_bytes(1);
        repeat (8) @(negedge clk);
        chk("R9", "error at write end", {63'd0, error}, 64'd1);
        chk("R9", "requests at write end", 64'(ga.size()), 64'd0);

        // R9 stream ends on a delay header
        do_reset();
        push_word({2'b10, 30'd3}, -1);
        run_bytes(1);
        repeat (8) @(negedge clk);
        chk("R9", "error at delay header", {63'd0, error}, 64'd1);
        chk("R9", "done at delay header", {63'd0, done}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule